// File: doc/BRIEF.md
# Colour-Select Binary Mask Pipeline

This block turns a raster stream of RGB565 pixels into a one-bit mask that marks where a chosen colour appears. Each pixel is reduced to a 4-bit colour class and a 4-bit gray level. A pixel whose class equals the programmed target keeps its gray level. Any other pixel becomes zero. The selected gray plane is then smoothed by a 3x3 box average and compared against a programmable 4-bit threshold, which gives one mask bit per pixel. The mask comes out in raster order, with its own start-of-frame and end-of-line flags.

Frame geometry is fixed by the parameters `WIDTH` and `HEIGHT`. A frame opens with `in_sof` on its first pixel. The block counts columns and rows by itself. Two internal line stores hold the previous two selected rows. The mask for a row is produced while the next row arrives, so the latency is one image line plus one cycle.

A small state machine sequences the frame. Its states and transitions are:
- `ST_IDLE` waits for a pixel with `in_sof`, then moves to `ST_FILL`.
- `ST_FILL` takes the first row and moves to `ST_RUN` after the last column.
- `ST_RUN` takes rows 1 to HEIGHT-1. It emits one mask bit per pixel after the first column, and moves to `ST_TAIL` after the last column.
- `ST_TAIL` spends one cycle feeding a zero right-hand column. It then returns to `ST_RUN` for the next row, goes to `ST_FLUSH` after the last input row, or goes back to `ST_IDLE` after the flushed row.
- `ST_FLUSH` feeds a zero bottom row, one column per cycle, and then enters `ST_TAIL`.

Top module: `colour_mask_pipe`

## Requirements
- R1: The colour class is {R[4:3], G[5:4]}, where R = in_pix[15:11], G = in_pix[10:5] and B = in_pix[4:0]. The gray level is ((2R + 2G + B) * 9) >> 7. The selected value is that gray level when the class equals cfg_target, and 0 otherwise.
- R2: For every pixel, let S be the sum of the nine selected values in its 3x3 neighbourhood. The mean is (S * 57) >> 9, and out_mask is 1 exactly when the mean is greater than or equal to cfg_thresh.
- R3: Neighbours outside the frame (above row 0, below row HEIGHT-1, left of column 0, right of column WIDTH-1) count as 0.
- R4: Each frame produces exactly WIDTH*HEIGHT mask outputs, in raster order, each marked by out_valid high for one cycle.
- R5: out_sof is high only with the output for row 0, column 0. out_eol is high only with the output for column WIDTH-1 of each row. Both are high only while out_valid is high.
- R6: Pixels presented while the block is idle without in_sof are ignored and produce no output.
- R7: The output for a pixel at row r, column c (with r < HEIGHT-1 and c < WIDTH-1) appears on the ports in the cycle after the clock edge that accepts input pixel (r+1, c+1).
- R8: After reset, out_valid, out_mask, out_sof and out_eol are 0.
- R9: Idle input cycles (in_valid low) inside a row do not change any mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 16 | RGB565 pixel |
| cfg_target | input | 4 | Colour class to keep |
| cfg_thresh | input | 4 | Mask threshold on the smoothed gray |
| out_valid | output | 1 | Mask bit present this cycle |
| out_mask | output | 1 | Binary mask bit |
| out_sof | output | 1 | Output for the first pixel of a frame |
| out_eol | output | 1 | Output for the last pixel of a row |

## Verification
The checks assume the source sends no pixel during the tail cycle after each row, or during the internally generated bottom row and its tail. They also assume a new frame starts only after the block has returned to idle, and that `cfg_target` and `cfg_thresh` stay fixed within a frame. The stimulus keeps within these limits. It leaves one idle cycle after every row and several idle cycles plus the width after every frame, and it changes configuration only between frames. Optional single-cycle gaps inside rows are allowed, because the machine simply holds its position while `in_valid` is low.

// File: rtl/cmask_pkg.sv
package cmask_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RUN,
        ST_TAIL,
        ST_FLUSH
    } phase_t;

    localparam int GRAY_W   = 4;
    localparam int TAPS     = 9;
    localparam int WIN_W    = TAPS * GRAY_W;
    localparam int MEAN_MUL = 57;
    localparam int MEAN_SH  = 9;

endpackage

// File: rtl/colour_select.sv
module colour_select
    import cmask_pkg::*;
(
    input  logic [15:0]       pix,
    input  logic [3:0]        target,
    output logic [GRAY_W-1:0] sel
);
    logic [4:0]  r5;
    logic [5:0]  g6;
    logic [4:0]  b5;
    logic [3:0]  cls;
    logic [7:0]  luma;
    logic [10:0] scaled;

    always_comb begin
        r5     = pix[15:11];
        g6     = pix[10:5];
        b5     = pix[4:0];
        cls    = {r5[4:3], g6[5:4]};
        luma   = 8'({r5, 1'b0}) + 8'({g6, 1'b0}) + 8'(b5);
        scaled = 11'(luma) * 11'd9;
        sel    = (cls == target) ? scaled[10:7] : '0;
    end
endmodule

// File: rtl/line_window.sv
module line_window
    import cmask_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int CW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              zero_col,
    input  logic              lb_wr,
    input  logic              top_ok,
    input  logic [CW-1:0]     col,
    input  logic [GRAY_W-1:0] bot,
    output logic [WIN_W-1:0]  win
);
    logic [GRAY_W-1:0] lb_old [WIDTH];
    logic [GRAY_W-1:0] lb_new [WIDTH];
    logic [GRAY_W-1:0] wc [3][3];
    logic [GRAY_W-1:0] vin [3];
    logic              restart;

    always_comb begin
        vin[0]  = (zero_col || !top_ok) ? '0 : lb_old[col];
        vin[1]  = zero_col ? '0 : lb_new[col];
        vin[2]  = zero_col ? '0 : bot;
        restart = (col == '0) && !zero_col;
    end

    always_ff @(posedge clk) begin
        if (step && lb_wr) begin
            lb_old[col] <= lb_new[col];
            lb_new[col] <= bot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++)
                for (int r = 0; r < 3; r++)
                    wc[c][r] <= '0;
        end else if (step) begin
            for (int r = 0; r < 3; r++) begin
                if (restart) begin
                    wc[0][r] <= '0;
                    wc[1][r] <= '0;
                end else begin
                    wc[0][r] <= wc[1][r];
                    wc[1][r] <= wc[2][r];
                end
                wc[2][r] <= vin[r];
            end
        end
    end

    for (genvar gc = 0; gc < 3; gc++) begin : g_col
        for (genvar gr = 0; gr < 3; gr++) begin : g_row
            assign win[(gc*3+gr)*GRAY_W +: GRAY_W] = wc[gc][gr];
        end
    end

    a_r3_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart) |=>
        ({wc[0][0], wc[0][1], wc[0][2], wc[1][0], wc[1][1], wc[1][2]} == '0));

    a_r3_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (step && zero_col) |=> ({wc[2][0], wc[2][1], wc[2][2]} == '0));

    a_r3_top_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !top_ok) |=> (wc[2][0] == '0));
endmodule

// File: rtl/mean_thresh.sv
module mean_thresh
    import cmask_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_ok,
    input  logic             win_sof,
    input  logic             win_eol,
    input  logic [WIN_W-1:0] win,
    input  logic [3:0]       thr,
    output logic             o_valid,
    output logic             o_mask,
    output logic             o_sof,
    output logic             o_eol
);
    localparam int SUM_W = 8;
    localparam int PRD_W = SUM_W + 5;

    logic [SUM_W-1:0]  sum;
    logic [PRD_W-1:0]  prod;
    logic [GRAY_W-1:0] mean;

    always_comb begin
        sum = '0;
        for (int i = 0; i < TAPS; i++)
            sum = sum + SUM_W'(win[i*GRAY_W +: GRAY_W]);
        prod = PRD_W'(sum) * PRD_W'(MEAN_MUL);
        mean = prod[MEAN_SH +: GRAY_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_mask  <= 1'b0;
            o_sof   <= 1'b0;
            o_eol   <= 1'b0;
        end else begin
            o_valid <= win_ok;
            o_mask  <= win_ok && (mean >= thr);
            o_sof   <= win_ok && win_sof;
            o_eol   <= win_ok && win_eol;
        end
    end

    a_r2_empty_window_low: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && sum == '0 && thr != '0) |=> (o_valid && !o_mask));
endmodule

// File: rtl/colour_mask_pipe.sv
module colour_mask_pipe
    import cmask_pkg::*;
#(
    parameter int WIDTH  = 64,
    parameter int HEIGHT = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [15:0] in_pix,
    input  logic [3:0]  cfg_target,
    input  logic [3:0]  cfg_thresh,
    output logic        out_valid,
    output logic        out_mask,
    output logic        out_sof,
    output logic        out_eol
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int RW = $clog2(HEIGHT + 1);
    localparam logic [CW-1:0] COL_LAST  = CW'(WIDTH - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(HEIGHT - 1);
    localparam logic [RW-1:0] ROW_FLUSH = RW'(HEIGHT);

    phase_t            state, nxt_state;
    logic [CW-1:0]     col, nxt_col;
    logic [RW-1:0]     row, nxt_row;
    logic              step, lb_wr, zero_col, emit, emit_sof, emit_eol, top_ok;
    logic              ok_q, sof_q, eol_q;
    logic [GRAY_W-1:0] sel_val, bot_val;
    logic [WIN_W-1:0]  win;

    colour_select u_sel (
        .pix    (in_pix),
        .target (cfg_target),
        .sel    (sel_val)
    );

    assign bot_val = (state == ST_FLUSH) ? '0 : sel_val;
    assign top_ok  = (row >= RW'(2));

    // state register, position counters and window flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            col   <= '0;
            row   <= '0;
            ok_q  <= 1'b0;
            sof_q <= 1'b0;
            eol_q <= 1'b0;
        end else begin
            state <= nxt_state;
            col   <= nxt_col;
            row   <= nxt_row;
            ok_q  <= emit;
            sof_q <= emit_sof;
            eol_q <= emit_eol;
        end
    end

    // next state and per-cycle controls
    always_comb begin
        nxt_state = state;
        nxt_col   = col;
        nxt_row   = row;
        step      = 1'b0;
        lb_wr     = 1'b0;
        zero_col  = 1'b0;
        emit      = 1'b0;
        emit_sof  = 1'b0;
        emit_eol  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    step      = 1'b1;
                    lb_wr     = 1'b1;
                    nxt_col   = CW'(1);
                    nxt_row   = '0;
                    nxt_state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    step  = 1'b1;
                    lb_wr = 1'b1;
                    if (col == COL_LAST) begin
                        nxt_col   = '0;
                        nxt_row   = RW'(1);
                        nxt_state = ST_RUN;
                    end else begin
                        nxt_col = col + CW'(1);
                    end
                end
            end
            ST_RUN: begin
                if (in_valid) begin
                    step     = 1'b1;
                    lb_wr    = 1'b1;
                    emit     = (col != '0);
                    emit_sof = (row == RW'(1)) && (col == CW'(1));
                    if (col == COL_LAST) nxt_state = ST_TAIL;
                    else                 nxt_col   = col + CW'(1);
                end
            end
            ST_TAIL: begin
                step     = 1'b1;
                zero_col = 1'b1;
                emit     = 1'b1;
                emit_eol = 1'b1;
                nxt_col  = '0;
                if (row == ROW_FLUSH) begin
                    nxt_row   = '0;
                    nxt_state = ST_IDLE;
                end else if (row == ROW_LAST) begin
                    nxt_row   = ROW_FLUSH;
                    nxt_state = ST_FLUSH;
                end else begin
                    nxt_row   = row + RW'(1);
                    nxt_state = ST_RUN;
                end
            end
            ST_FLUSH: begin
                step = 1'b1;
                emit = (col != '0);
                if (col == COL_LAST) nxt_state = ST_TAIL;
                else                 nxt_col   = col + CW'(1);
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    line_window #(.WIDTH(WIDTH), .CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .zero_col (zero_col),
        .lb_wr    (lb_wr),
        .top_ok   (top_ok),
        .col      (col),
        .bot      (bot_val),
        .win      (win)
    );

    mean_thresh u_mean (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_ok  (ok_q),
        .win_sof (sof_q),
        .win_eol (eol_q),
        .win     (win),
        .thr     (cfg_thresh),
        .o_valid (out_valid),
        .o_mask  (out_mask),
        .o_sof   (out_sof),
        .o_eol   (out_eol)
    );

    initial begin
        if (WIDTH < 2 || HEIGHT < 2) $error("WIDTH and HEIGHT must be at least 2");
    end

    a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r5_eol_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE && $past(state, 2) == ST_IDLE)
        |-> !out_valid);

    a_r4_tail_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |=> (state != ST_TAIL));
endmodule

// File: tb/sim_colour_mask_pipe.sv
module sim_colour_mask_pipe;
    localparam int W = 6;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [15:0] in_pix = '0;
    logic [3:0]  cfg_target = '0;
    logic [3:0]  cfg_thresh = '0;
    logic        out_valid, out_mask, out_sof, out_eol;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t_in = 0;
    int n_out = 0;
    bit ended = 0;
    int unsigned seed = 32'h1234_5678;
    logic [2:0]  expq [$];
    logic [2:0]  mon_e;
    logic [15:0] pix_m [H][W];
    int          sel_m [H][W];

    colour_mask_pipe #(.WIDTH(W), .HEIGHT(H)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_pix     (in_pix),
        .cfg_target (cfg_target),
        .cfg_thresh (cfg_thresh),
        .out_valid  (out_valid),
        .out_mask   (out_mask),
        .out_sof    (out_sof),
        .out_eol    (out_eol)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    // R1 reference: class {R[4:3],G[5:4]}, gray ((2R+2G+B)*9)>>7
    function automatic int sel_of(logic [15:0] p, logic [3:0] tgt);
        int y;
        logic [3:0] cls;
        cls = {p[15:14], p[10:9]};
        y = 2 * int'(p[15:11]) + 2 * int'(p[10:5]) + int'(p[4:0]);
        return (cls == tgt) ? ((y * 9) >> 7) : 0;
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (expq.size() == 0) begin
                check("R4/R6 unexpected output", 1'b0, 1, 0);
            end else begin
                mon_e = expq.pop_front();
                check("R2 mask (R1 select, R3 padding)", out_mask == mon_e[2], out_mask, mon_e[2]);
                check("R5 sof flag", out_sof == mon_e[1], out_sof, mon_e[1]);
                check("R5 eol flag", out_eol == mon_e[0], out_eol, mon_e[0]);
                if (out_sof) check("R7 latency", (cyc - t_in) == 2, cyc - t_in, 2);
            end
        end
    end

    // driver: builds a frame, pushes expected items, then streams it
    task automatic send_frame(input int mode, input bit gaps);
        int s, mean;
        logic [3:0] cls;
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (mode == 1) begin
                    pix_m[r][c] = 16'hFFFF;
                end else begin
                    cls = (rnd() % 2 == 1) ? cfg_target : 4'(rnd());
                    pix_m[r][c] = {cls[3:2], 3'(rnd()), cls[1:0], 4'(rnd()), 5'(rnd())};
                end
                sel_m[r][c] = sel_of(pix_m[r][c], cfg_target);
            end
        end
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                s = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (r + dr >= 0 && r + dr < H && c + dc >= 0 && c + dc < W)
                            s += sel_m[r + dr][c + dc];
                mean = (s * 57) >> 9;
                expq.push_back({mean >= int'(cfg_thresh), r == 0 && c == 0, c == W - 1});
            end
        end
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps && (c % 2 == 1)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sof   = 1'b0;
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = pix_m[r][c];
                in_sof   = (r == 0 && c == 0);
                if (r == 1 && c == 1) t_in = cyc;
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
        repeat (W + 8) @(negedge clk);
    endtask

    initial begin
        int bad0;
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", out_valid == 1'b0, out_valid, 0);
        check("R8 reset out_mask", out_mask == 1'b0, out_mask, 0);
        check("R8 reset flags", {out_sof, out_eol} == 2'b00, {out_sof, out_eol}, 0);
        rst_n = 1'b1;

        // R6: stray pixels with no frame start
        cfg_target = 4'h6;
        cfg_thresh = 4'd0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_pix   = 16'hFFFF;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 idle pixels ignored", n_out == 0, n_out, 0);

        cfg_target = 4'h6;
        cfg_thresh = 4'd5;
        send_frame(0, 1'b0);

        bad0 = n_bad;
        cfg_target = 4'hA;
        cfg_thresh = 4'd3;
        send_frame(0, 1'b1);
        check("R9 gaps leave masks unchanged", n_bad == bad0, n_bad - bad0, 0);

        bad0 = n_bad;
        cfg_target = 4'hF;
        cfg_thresh = 4'd15;
        send_frame(1, 1'b0);
        check("R3 border zero padding", n_bad == bad0, n_bad - bad0, 0);

        cfg_target = 4'h2;
        cfg_thresh = 4'd0;
        send_frame(0, 1'b0);

        bad0 = n_bad;
        cfg_target = 4'h0;
        cfg_thresh = 4'd1;
        send_frame(1, 1'b0);
        check("R1 non-target class discarded", n_bad == bad0, n_bad - bad0, 0);

        check("R4 queue drained", expq.size() == 0, expq.size(), 0);
        check("R4 output count", n_out == 5 * W * H, n_out, 5 * W * H);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1'b0, cyc, 0);
        finish_run();
    end
endmodule